// File: doc/BRIEF.md
# Half-Bridge Interlock and Deadtime Generator

This block converts two PWM command inputs into the gate enables of a half-bridge: one for the low-side switch and one for the high-side switch. The low-side command is active low and the high-side command is active high. Either input can be driven on its own. If both are tied to one control signal, that signal produces complementary drive: high selects the high side and low selects the low side. A drive enable from the shutdown sequencer takes priority and forces both gates off whenever it is low.

Decoding is registered, so both gate enables change on the clock edge after a command. A gate always turns off on that next edge. A gate turns on only after the opposite gate has been off for the programmed deadtime. The deadtime is a count of clock cycles, and a programmed zero is raised to a minimum of one cycle. The same rule applies to both transition directions, so the low-to-high and high-to-low deadtimes match by construction.

The deadtime therefore delays a turn-on only when the opposite gate switched off recently. Commands that are already separated by more than the deadtime reach the gates with just the one register stage of latency.

Top module: `hb_deadtime_gen`

## Requirements
- R1: When `drive_en` is low at a clock edge, both `gate_lo` and `gate_hi` are 0 after that edge, whatever the commands are.
- R2: With the enable high, `lo_cmd_n`=1 and `hi_cmd`=0 request neither switch, and both gates are 0 after the edge.
- R3: With the enable high, `lo_cmd_n`=0 and `hi_cmd`=0 request the low side. `gate_hi` is 0 after the edge, and `gate_lo` becomes 1 once the deadtime rule of R7 allows it.
- R4: With the enable high, `lo_cmd_n`=1 and `hi_cmd`=1 request the high side. `gate_lo` is 0 after the edge, and `gate_hi` becomes 1 once R7 allows it.
- R5: With the enable high, `lo_cmd_n`=0 and `hi_cmd`=1 request both switches. The interlock makes both gates 0 after the edge.
- R6: A gate whose request is withdrawn turns off on the very next clock edge. Turn-off is never delayed.
- R7: A gate may turn on only after the opposite gate has been 0 for at least `max(dead_cycles,1)` consecutive cycles. The same count applies to both sides.
- R8: If the opposite gate has already been off for at least the deadtime, a requested gate turns on at the next edge with no added delay.
- R9: `gate_lo` and `gate_hi` are never 1 in the same cycle.
- R10: After reset, both gates are 0 and both sides count as having been off indefinitely. The first turn-on therefore waits for no deadtime.
- R11: With one signal driving both `lo_cmd_n` and `hi_cmd`, a 1 selects the high side and a 0 selects the low side, and every change of the signal inserts the deadtime.
- R12: A turn-on still waiting for its deadtime is cancelled if its request goes away before the wait ends. That gate then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cmd_n | input | 1 | Low-side command, active low |
| hi_cmd | input | 1 | High-side command, active high |
| drive_en | input | 1 | Drive enable from the shutdown sequencer |
| dead_cycles | input | DT_W (10) | Deadtime in clock cycles; 0 behaves as 1 |
| gate_lo | output | 1 | Low-side gate enable, registered |
| gate_hi | output | 1 | High-side gate enable, registered |

## Verification
The bench builds the block with the default 10-bit deadtime width. This keeps the off-time counters saturating at 1023, which is far above every deadtime used in the bench. The deadtime is swept across 0, 1, small values and a few tens of cycles. That range reaches the cases where a command edge falls inside the window, where a gap exceeds it, and the clamp of zero to one cycle. Random command runs of varied lengths also toggle the enable and switch into tied-input mode, so overlap, cancellation and back-to-back reversals occur many times within the cycle budget.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

    localparam int LEG_LO = 0;
    localparam int LEG_HI = 1;
    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LOW  = 2'd1,
        REQ_HIGH = 2'd2
    } leg_req_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // Decode the command pins into one leg request; both-on folds to none.
    function automatic leg_req_e decode_cmd(input logic lo_n, input logic hi,
                                            input logic en);
        leg_req_e r;
        if (!en)                r = REQ_NONE;
        else if (!lo_n && hi)   r = REQ_NONE;
        else if (!lo_n)         r = REQ_LOW;
        else if (hi)            r = REQ_HIGH;
        else                    r = REQ_NONE;
        return r;
    endfunction

    function automatic gate_pair_t req_to_want(input leg_req_e r);
        gate_pair_t w;
        w.lo = (r == REQ_LOW);
        w.hi = (r == REQ_HIGH);
        return w;
    endfunction

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
    import hb_dt_pkg::*;
(
    input  logic       lo_cmd_n,
    input  logic       hi_cmd,
    input  logic       drive_en,
    output gate_pair_t want
);
    leg_req_e req;

    always_comb begin
        req  = decode_cmd(lo_cmd_n, hi_cmd, drive_en);
        want = req_to_want(req);
    end

    // R5: an overlapping request never asks for both legs
    always_comb begin
        both_req_chk: assert (!(want.lo && want.hi));
    end
endmodule

// File: rtl/hb_off_timer.sv
module hb_off_timer #(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gate_q,
    output logic [DT_W-1:0] off_cnt
);
    localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

    // Cycles the gate has been low, saturating; reset counts as long off.
    always_ff @(posedge clk) begin
        if (rst)                    off_cnt <= CNT_MAX;
        else if (gate_q)            off_cnt <= '0;
        else if (off_cnt != CNT_MAX) off_cnt <= off_cnt + 1'b1;
    end
endmodule

// File: rtl/hb_gate_arbiter.sv
module hb_gate_arbiter
    import hb_dt_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  gate_pair_t      want,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic [DT_W-1:0] off_lo,
    input  logic [DT_W-1:0] off_hi,
    output gate_pair_t      gate_q
);
    logic [DT_W-1:0] need_m1;
    logic [NUM_LEGS-1:0] want_v, gate_v, next_v;
    logic [DT_W-1:0] off_v [NUM_LEGS];

    always_comb begin
        need_m1 = (dead_cycles == '0) ? '0 : dead_cycles - 1'b1;
        want_v  = {want.hi, want.lo};
        gate_v  = {gate_q.hi, gate_q.lo};
        off_v[LEG_LO] = off_lo;
        off_v[LEG_HI] = off_hi;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        localparam int OPP = NUM_LEGS - 1 - g;
        // Turn-on waits for the opposite leg's off time; turn-off is immediate.
        assign next_v[g] = want_v[g] && !gate_v[OPP] && (off_v[OPP] >= need_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else begin
            gate_q.lo <= next_v[LEG_LO];
            gate_q.hi <= next_v[LEG_HI];
        end
    end
endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen
    import hb_dt_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lo_cmd_n,
    input  logic            hi_cmd,
    input  logic            drive_en,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_lo,
    output logic            gate_hi
);
    localparam logic [DT_W:0] CHK_MAX = {(DT_W+1){1'b1}};

    gate_pair_t want;
    gate_pair_t gate_q;
    logic [DT_W-1:0] off_lo;
    logic [DT_W-1:0] off_hi;

    hb_cmd_decode u_dec (
        .lo_cmd_n (lo_cmd_n),
        .hi_cmd   (hi_cmd),
        .drive_en (drive_en),
        .want     (want)
    );

    hb_off_timer #(.DT_W(DT_W)) u_tmr_lo (
        .clk (clk), .rst (rst), .gate_q (gate_q.lo), .off_cnt (off_lo)
    );

    hb_off_timer #(.DT_W(DT_W)) u_tmr_hi (
        .clk (clk), .rst (rst), .gate_q (gate_q.hi), .off_cnt (off_hi)
    );

    hb_gate_arbiter #(.DT_W(DT_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .want        (want),
        .dead_cycles (dead_cycles),
        .off_lo      (off_lo),
        .off_hi      (off_hi),
        .gate_q      (gate_q)
    );

    assign gate_lo = gate_q.lo;
    assign gate_hi = gate_q.hi;

    // Assertion-side bookkeeping: armed after one clean cycle, plus
    // independent wide off-time counters seeded as long off.
    logic          armed;
    logic [DT_W:0] chk_off_lo, chk_off_hi;
    logic [DT_W:0] need_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            chk_off_lo <= CHK_MAX;
            chk_off_hi <= CHK_MAX;
        end else begin
            armed      <= 1'b1;
            chk_off_lo <= gate_lo ? '0 : ((chk_off_lo == CHK_MAX) ? chk_off_lo : chk_off_lo + 1'b1);
            chk_off_hi <= gate_hi ? '0 : ((chk_off_hi == CHK_MAX) ? chk_off_hi : chk_off_hi + 1'b1);
        end
    end

    assign need_eff = (dead_cycles == '0) ? {{DT_W{1'b0}}, 1'b1} : {1'b0, dead_cycles};

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_lo && gate_hi));

    // R1
    en_off_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(drive_en) |-> (!gate_lo && !gate_hi));

    // R5
    both_req_off_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(drive_en) && !$past(lo_cmd_n) && $past(hi_cmd)) |-> (!gate_lo && !gate_hi));

    // R6
    lo_release_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(lo_cmd_n) |-> !gate_lo);

    // R6
    hi_release_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(hi_cmd) |-> !gate_hi);

    // R7
    hi_dead_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(gate_hi) |-> (({1'b0, $past(chk_off_lo)} + 1'b1) >= {1'b0, $past(need_eff)}));

    // R7
    lo_dead_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(gate_lo) |-> (({1'b0, $past(chk_off_hi)} + 1'b1) >= {1'b0, $past(need_eff)}));
endmodule

// File: tb/hb_deadtime_gen_tb.sv
`timescale 1ns/1ps
module hb_deadtime_gen_tb;
    localparam int DT_W = 10;
    localparam int CMAX = (1 << DT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lo_cmd_n = 1'b1;
    logic hi_cmd = 1'b0;
    logic drive_en = 1'b0;
    logic [DT_W-1:0] dead_cycles = '0;
    logic gate_lo, gate_hi;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // reference state
    bit m_lo, m_hi;
    int m_off_lo, m_off_hi;

    always #2.5 clk = ~clk;

    hb_deadtime_gen #(.DT_W(DT_W)) u_dut (
        .clk (clk), .rst (rst), .lo_cmd_n (lo_cmd_n), .hi_cmd (hi_cmd),
        .drive_en (drive_en), .dead_cycles (dead_cycles),
        .gate_lo (gate_lo), .gate_hi (gate_hi)
    );

    function automatic int eff_dead(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int sat_inc(input int c);
        return (c >= CMAX) ? CMAX : c + 1;
    endfunction

    task automatic model_reset();
        m_lo = 0; m_hi = 0; m_off_lo = CMAX; m_off_hi = CMAX;
    endtask

    // One clock edge of the requirement-level behaviour.
    task automatic model_edge(input bit ln, input bit h, input bit e, input int d);
        bit want_lo, want_hi, n_lo, n_hi;
        want_lo = e && !ln && !h;
        want_hi = e && ln && h;
        n_lo = want_lo && !m_hi && (m_off_hi + 1 >= eff_dead(d));
        n_hi = want_hi && !m_lo && (m_off_lo + 1 >= eff_dead(d));
        m_off_lo = m_lo ? 0 : sat_inc(m_off_lo);
        m_off_hi = m_hi ? 0 : sat_inc(m_off_hi);
        m_lo = n_lo; m_hi = n_hi;
    endtask

    task automatic check(input string tag);
        n_checks++;
        if (gate_lo !== m_lo || gate_hi !== m_hi) begin
            n_errors++;
            $display("FAIL %s: got lo=%b hi=%b expected lo=%b hi=%b at %0t",
                     tag, gate_lo, gate_hi, m_lo, m_hi, $time);
        end
        if (gate_lo === 1'b1 && gate_hi === 1'b1) begin
            n_errors++;
            $display("FAIL R9 overlap: got lo=1 hi=1 expected not both at %0t", $time);
        end
    endtask

    task automatic step(input bit ln, input bit h, input bit e, input string tag);
        lo_cmd_n = ln; hi_cmd = h; drive_en = e;
        @(posedge clk);
        model_edge(ln, h, e, int'(dead_cycles));
        @(negedge clk);
        check(tag);
    endtask

    task automatic hold(input bit ln, input bit h, input bit e, input int n, input string tag);
        for (int i = 0; i < n; i++) step(ln, h, e, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();
        check("R10 reset state");

        // R10: first turn-on with no wait even with a long deadtime
        dead_cycles = 10'd5;
        step(0, 0, 1, "R10 first turn-on immediate");
        hold(0, 0, 1, 3, "R3 low requested");
        // R4 / R7: reversal waits 5 cycles
        hold(1, 1, 1, 8, "R7 high waits deadtime");
        // R6: release immediate
        step(1, 0, 1, "R6 release");
        step(1, 0, 1, "R2 none requested");
        // R8: gap longer than deadtime
        hold(1, 0, 1, 6, "R2 idle");
        step(0, 0, 1, "R8 no extra delay");
        hold(0, 0, 1, 2, "R3 low held");
        // R5 overlap then high: deadtime still counted from low off
        hold(0, 1, 1, 2, "R5 overlap both off");
        hold(1, 1, 1, 5, "R7 after overlap");
        // R1 enable low
        hold(1, 1, 0, 3, "R1 enable low");
        hold(0, 0, 0, 2, "R1 enable low low-req");
        // R12 cancellation
        dead_cycles = 10'd8;
        hold(1, 1, 1, 3, "R4 high on");
        hold(0, 0, 1, 3, "R12 pending low");
        hold(1, 0, 1, 12, "R12 cancelled stays off");
        // R7 deadtime zero acts as one
        dead_cycles = 10'd0;
        hold(0, 0, 1, 2, "R7 dt0 low");
        hold(1, 1, 1, 3, "R7 dt0 high");
        hold(0, 0, 1, 3, "R7 dt0 back");
        // R11 tied input, deadtime 3
        dead_cycles = 10'd3;
        for (int k = 0; k < 6; k++) begin
            bit s;
            s = k[0];
            hold(s, s, 1, 2 + k, "R11 tied");
        end
        // R7 longer deadtime, both directions
        dead_cycles = 10'd40;
        hold(1, 1, 1, 45, "R7 dt40 high");
        hold(0, 0, 1, 45, "R7 dt40 low");

        // random phase
        for (int blk = 0; blk < 600; blk++) begin
            int len, mode;
            bit ln, h, e;
            if ($urandom_range(0, 7) == 0) begin
                case ($urandom_range(0, 3))
                    0: dead_cycles = 10'd0;
                    1: dead_cycles = 10'd1;
                    2: dead_cycles = DT_W'($urandom_range(2, 6));
                    default: dead_cycles = DT_W'($urandom_range(7, 30));
                endcase
            end
            len = $urandom_range(1, 12);
            mode = $urandom_range(0, 3);
            e = ($urandom_range(0, 9) != 0);
            if (mode == 0) begin
                ln = 1'($urandom_range(0, 1)); h = ln;
            end else begin
                ln = 1'($urandom_range(0, 1)); h = 1'($urandom_range(0, 1));
            end
            hold(ln, h, e, len, "R9 R7 random");
        end

        // R10 again after a mid-run reset
        do_reset();
        check("R10 second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule